// File: doc/BRIEF.md
# Grant-Timed DMA Handshake Master

This block lets a terminal core move one 16-bit word to or from a subsystem memory through a handshake that the device starts itself. The core hands over a transfer on a valid/ready request channel: a direction (read brings a word from the subsystem into the device; write sends a word from the device out to the subsystem), a word address and, for writes, the data. The block then pulls its active-low request low and waits for the subsystem's active-low grant. Once the grant is seen, it drives acknowledge and chip select low, along with the address and the direction level. The direction output is high for a read and low for a write.

The block can run with a full 16-bit data path or with a byte-wide one. In byte mode each word is carried as two byte beats inside a single handshake. The upper byte goes first, with address bit 0 set. The lower byte follows, with address bit 0 clear. If the grant does not arrive within a programmable number of cycles, the block gives up. It releases its request, pulls the sticky handshake-fail pin low and sets a sticky flag in a built-in-test status word. It then tells the core what to do next: abort the message for a failed read, so that no bad data reaches the bus, or keep going for a failed write.

The result comes back on a valid/ready response channel. The response is held unchanged until the core takes it. The request channel accepts nothing until that response has been taken.

Top module: `dma_hs_master`

## Requirements
- R1: After reset, request, acknowledge, chip select and handshake-fail are all high, the status word is zero, req_ready is 1 and rsp_valid is 0.
- R2: Acknowledge and chip select go low only while request is low and only after grant has been sampled low. The direction output is 1 during read beats and 0 during write beats.
- R3: When byte_mode=0, a read makes exactly one beat at mem_addr = {req_addr, 1'b0} and returns the full 16-bit mem_din of that beat on rsp_rdata.
- R4: When byte_mode=0, a write makes exactly one beat at mem_addr = {req_addr, 1'b0} with mem_dout equal to req_wdata.
- R5: When byte_mode=1, a read makes two beats in one handshake. The first is at address bit 0 = 1 and the second at bit 0 = 0. rsp_rdata is {first beat mem_din[7:0], second beat mem_din[7:0]}.
- R6: When byte_mode=1, a write makes two beats. The first has address bit 0 = 1 and mem_dout = {8'h00, req_wdata[15:8]}. The second has bit 0 = 0 and mem_dout = {8'h00, req_wdata[7:0]}.
- R7: Grant is sampled once per cycle from the first cycle after request falls, counting that cycle as 0. If grant is first low in cycle d, the transfer succeeds when d <= tmo_limit. Otherwise it times out after cycle tmo_limit, with no acknowledge beat.
- R8: A timed-out transfer responds with rsp_fail=1. rsp_abort is 1 for a read and 0 for a write. A successful transfer responds with rsp_fail=0 and rsp_abort=0.
- R9: A timeout drives hs_fail_n low. It stays low until a cycle with fail_clr=1 and no new timeout; bit_rd has no effect on it.
- R10: A timeout sets bit_word[12]. It stays set until a cycle with bit_rd=1 and no new timeout; fail_clr has no effect on it. All other bits of bit_word are 0.
- R11: req_ready is 0 from acceptance until the response is taken. While rsp_valid=1 and rsp_ready=0, the response fields hold steady.
- R12: While the response is presented, request and acknowledge are both released (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = two byte beats per word, 0 = one 16-bit beat; sampled at acceptance |
| tmo_limit | input | TMO_W | Last request cycle in which grant is still accepted |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Block accepts a transfer this cycle |
| req_write | input | 1 | 1 = device to subsystem, 0 = subsystem to device |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | Result is presented |
| rsp_ready | input | 1 | Core takes the result |
| rsp_rdata | output | DATA_W | Word read |
| rsp_fail | output | 1 | Transfer timed out |
| rsp_abort | output | 1 | Abort the current message (failed read) |
| rq_n | output | 1 | Active-low request |
| gnt_n | input | 1 | Active-low grant |
| ack_n | output | 1 | Active-low acknowledge |
| cs_n | output | 1 | Active-low chip select |
| wrt | output | 1 | Direction: 1 read, 0 write |
| mem_addr | output | ADDR_W+1 | {word address, byte select} |
| mem_dout | output | DATA_W | Data to subsystem |
| mem_din | input | DATA_W | Data from subsystem |
| hs_fail_n | output | 1 | Sticky active-low handshake failure |
| fail_clr | input | 1 | Releases hs_fail_n |
| bit_rd | input | 1 | Status word read; clears its fail flag |
| bit_word | output | DATA_W | Built-in-test status word; bit 12 = handshake failure |

## Verification
Random traffic mixes both directions, both data widths, deadlines from 0 to 7 and grant delays from 0 to 10. Comparing the delay against the deadline separates on-time grants from timeouts. The write/read split then separates the abort answer from the continue answer. Directed cases probe the delay exactly at the deadline and one cycle past it, a zero deadline, and a grant that never comes. They also clear the two sticky flags in both orders, which shows that each clear input affects only its own flag. The subsystem data depends on the full beat address, so a swapped byte order or a wrong address bit 0 changes the word that comes back.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_RESP = 2'd3
  } hs_state_e;

  // position of the handshake failure flag inside the status word
  localparam int unsigned HS_FAIL_BIT = 12;
endpackage

// File: rtl/dma_hs_timer.sv
// Counts cycles spent waiting for grant; flags when the deadline is reached.
module dma_hs_timer #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/dma_hs_lane.sv
// Byte-lane sequencing: beat address bit, outgoing lane data, read assembly.
module dma_hs_lane #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              beat,
  input  logic              capture,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              abit,
  output logic              last,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [HALF-1:0] wbyte;

  always_comb begin
    wbyte = beat ? wdata[HALF-1:0] : wdata[DATA_W-1:HALF];
    if (byte_mode) begin
      abit = !beat;
      last = beat;
      dout = {{(DATA_W-HALF){1'b0}}, wbyte};
    end else begin
      abit = 1'b0;
      last = 1'b1;
      dout = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      if (!byte_mode)  rdata <= din;
      else if (!beat)  rdata[DATA_W-1:HALF] <= din[HALF-1:0];
      else             rdata[HALF-1:0] <= din[HALF-1:0];
    end
  end
endmodule

// File: rtl/dma_hs_flags.sv
// Sticky failure indications; a new failure outranks a clear in the same cycle.
module dma_hs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_set,
  input  logic fail_clr,
  input  logic bit_rd,
  output logic hs_fail_n,
  output logic bit_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_fail_n <= 1'b1;
      bit_flag  <= 1'b0;
    end else begin
      if (fail_set)      hs_fail_n <= 1'b0;
      else if (fail_clr) hs_fail_n <= 1'b1;
      if (fail_set)      bit_flag <= 1'b1;
      else if (bit_rd)   bit_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_hs_master.sv
module dma_hs_master
  import dma_hs_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_fail,
  output logic              rsp_abort,
  output logic              rq_n,
  input  logic              gnt_n,
  output logic              ack_n,
  output logic              cs_n,
  output logic              wrt,
  output logic [ADDR_W:0]   mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              hs_fail_n,
  input  logic              fail_clr,
  input  logic              bit_rd,
  output logic [DATA_W-1:0] bit_word
);
  hs_state_e         state_q;
  logic              op_write_q, op_byte_q, beat_q, fail_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;

  logic              expired, in_xfer, abit, last, bit_flag, fail_set;
  logic [DATA_W-1:0] lane_dout;

  assign in_xfer  = (state_q == ST_XFER);
  assign fail_set = (state_q == ST_REQ) && gnt_n && expired;

  dma_hs_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_REQ),
    .limit(tmo_limit), .expired(expired)
  );

  dma_hs_lane #(.DATA_W(DATA_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .byte_mode(op_byte_q), .beat(beat_q),
    .capture(in_xfer && !op_write_q), .wdata(op_wdata_q), .din(mem_din),
    .dout(lane_dout), .abit(abit), .last(last), .rdata(rsp_rdata)
  );

  dma_hs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .fail_set(fail_set), .fail_clr(fail_clr),
    .bit_rd(bit_rd), .hs_fail_n(hs_fail_n), .bit_flag(bit_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      op_byte_q  <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      beat_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          op_write_q <= req_write;
          op_byte_q  <= byte_mode;
          op_addr_q  <= req_addr;
          op_wdata_q <= req_wdata;
          beat_q     <= 1'b0;
          fail_q     <= 1'b0;
          state_q    <= ST_REQ;
        end
        ST_REQ: begin
          if (!gnt_n) begin
            state_q <= ST_XFER;
          end else if (expired) begin
            fail_q  <= 1'b1;
            state_q <= ST_RESP;
          end
        end
        ST_XFER: begin
          if (last) state_q <= ST_RESP;
          else      beat_q  <= 1'b1;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    rsp_valid = (state_q == ST_RESP);
    rsp_fail  = fail_q;
    rsp_abort = fail_q && !op_write_q;
    rq_n      = !((state_q == ST_REQ) || in_xfer);
    ack_n     = !in_xfer;
    cs_n      = !in_xfer;
    wrt       = in_xfer ? !op_write_q : 1'b1;
    mem_addr  = in_xfer ? {op_addr_q, abit} : '0;
    mem_dout  = (in_xfer && op_write_q) ? lane_dout : '0;
    bit_word  = '0;
    bit_word[HS_FAIL_BIT] = bit_flag;
  end
endmodule

// File: rtl/dma_hs_checker.sv
module dma_hs_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_fail,
  input logic              rq_n,
  input logic              ack_n,
  input logic              cs_n,
  input logic              hs_fail_n,
  input logic              fail_clr,
  input logic              bit_rd,
  input logic [DATA_W-1:0] bit_word
);
  a_r2_ack_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !rq_n);
  a_r2_cs_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ack_n);
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!rq_n));
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_fail));
  a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r12_released: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rq_n && ack_n);
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_fail_n && !fail_clr |=> !hs_fail_n);
  a_r10_bit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bit_word[12] && !bit_rd |=> bit_word[12]);
  a_r7_fail_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> ack_n && rsp_valid && rsp_fail);
  a_r10_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bit_word) <= 1);
endmodule

bind dma_hs_master dma_hs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail),
  .rq_n(rq_n), .ack_n(ack_n), .cs_n(cs_n), .hs_fail_n(hs_fail_n),
  .fail_clr(fail_clr), .bit_rd(bit_rd), .bit_word(bit_word)
);

// File: tb/tb_dma_hs_master.sv
`timescale 1ns/1ps
module tb_dma_hs_master;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0;
  logic [TW-1:0] tmo_limit = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_fail, rsp_abort;
  logic [DW-1:0] rsp_rdata, mem_dout, mem_din, bit_word;
  logic rq_n, ack_n, cs_n, wrt, hs_fail_n;
  logic gnt_n = 1'b1;
  logic [AW:0] mem_addr;
  logic fail_clr = 1'b0, bit_rd = 1'b0;

  int tests = 0, fails = 0, cycles = 0;
  int gdelay = 0, gcnt = 0;
  int nbeat = 0;
  logic [AW:0]   b_addr [4];
  logic [DW-1:0] b_data [4];
  logic          b_wrt  [4];

  always #2.5 clk = ~clk;

  dma_hs_master #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .tmo_limit(tmo_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail),
    .rsp_abort(rsp_abort), .rq_n(rq_n), .gnt_n(gnt_n), .ack_n(ack_n),
    .cs_n(cs_n), .wrt(wrt), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_din(mem_din), .hs_fail_n(hs_fail_n), .fail_clr(fail_clr),
    .bit_rd(bit_rd), .bit_word(bit_word)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW:0] a);
    logic [31:0] p;
    p = {18'd0, a} * 32'd40503;
    return p[DW-1:0] ^ 16'hA5C3;
  endfunction

  assign mem_din = mem_f(mem_addr);

  // subsystem grant model: grant low from request cycle gdelay onward
  always @(negedge clk) begin
    if (rq_n) begin
      gcnt  <= 0;
      gnt_n <= 1'b1;
    end else begin
      gnt_n <= !(gcnt >= gdelay);
      gcnt  <= gcnt + 1;
    end
  end

  // beat recorder
  always @(negedge clk) begin
    if (!ack_n) begin
      if (nbeat < 4) begin
        b_addr[nbeat] = mem_addr;
        b_data[nbeat] = mem_dout;
        b_wrt[nbeat]  = wrt;
      end
      nbeat = nbeat + 1;
      tests++;
      if (rq_n || cs_n) begin
        fails++;
        $display("FAIL R2 ack without req/cs: rq_n=%0b cs_n=%0b expected 0 0", rq_n, cs_n);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input bit wr, input bit bm, input int lim, input int dly,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd, input int hold);
    bit exp_fail;
    logic [DW-1:0] hi, lo, exp_rd;
    int n_exp, guard;
    exp_fail = dly > lim;
    n_exp = exp_fail ? 0 : (bm ? 2 : 1);
    @(negedge clk);
    byte_mode = bm; tmo_limit = lim[TW-1:0]; gdelay = dly;
    req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    nbeat = 0;
    chk(req_ready == 1'b1, "R11 ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0 && rq_n == 1'b0, "R11 busy after accept / R2 request low",
        {req_ready, rq_n}, 0);
    guard = 0;
    while (!rsp_valid && guard < 400) begin @(negedge clk); guard++; end
    chk(rsp_valid == 1'b1, "R7 response arrives", rsp_valid, 1);
    chk(rq_n && ack_n, "R12 released at response", {rq_n, ack_n}, 2'b11);
    chk(nbeat == n_exp, "R7 beat count (R3 R4 R5 R6)", nbeat, n_exp);
    chk(rsp_fail == exp_fail, "R8 fail flag", rsp_fail, exp_fail);
    chk(rsp_abort == (exp_fail && !wr), "R8 abort flag", rsp_abort, exp_fail && !wr);
    if (exp_fail) begin
      chk(hs_fail_n == 1'b0, "R9 fail pin low", hs_fail_n, 0);
      chk(bit_word == 16'h1000, "R10 status bit 12", bit_word, 16'h1000);
    end else if (nbeat == n_exp) begin
      for (int i = 0; i < n_exp; i++)
        chk(b_wrt[i] == !wr, "R2 direction level", b_wrt[i], !wr);
      if (!bm) begin
        chk(b_addr[0] == {a, 1'b0}, wr ? "R4 beat address" : "R3 beat address", b_addr[0], {a, 1'b0});
        if (wr) chk(b_data[0] == wd, "R4 write data", b_data[0], wd);
        else    chk(rsp_rdata == mem_f({a, 1'b0}), "R3 read data", rsp_rdata, mem_f({a, 1'b0}));
      end else begin
        chk(b_addr[0] == {a, 1'b1} && b_addr[1] == {a, 1'b0},
            wr ? "R6 beat order" : "R5 beat order", {b_addr[0], b_addr[1]}, {a, 1'b1, a, 1'b0});
        if (wr) begin
          chk(b_data[0] == {8'h00, wd[15:8]}, "R6 upper lane", b_data[0], {8'h00, wd[15:8]});
          chk(b_data[1] == {8'h00, wd[7:0]}, "R6 lower lane", b_data[1], {8'h00, wd[7:0]});
        end else begin
          hi = mem_f({a, 1'b1}); lo = mem_f({a, 1'b0});
          exp_rd = {hi[7:0], lo[7:0]};
          chk(rsp_rdata == exp_rd, "R5 assembled read", rsp_rdata, exp_rd);
        end
      end
    end
    // back-pressure hold
    exp_rd = rsp_rdata;
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp_rd && rsp_fail == exp_fail, "R11 response held",
        rsp_rdata, exp_rd);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 response taken", {rsp_valid, req_ready}, 1);
  endtask

  task automatic clear_flags(input bit bit_first);
    @(negedge clk);
    if (bit_first) bit_rd = 1'b1; else fail_clr = 1'b1;
    @(negedge clk);
    bit_rd = 1'b0; fail_clr = 1'b0;
    if (bit_first) begin
      chk(bit_word == 16'h0, "R10 cleared by bit_rd", bit_word, 0);
      chk(hs_fail_n == 1'b0, "R9 unaffected by bit_rd", hs_fail_n, 0);
    end else begin
      chk(hs_fail_n == 1'b1, "R9 cleared by fail_clr", hs_fail_n, 1);
      chk(bit_word == 16'h1000, "R10 unaffected by fail_clr", bit_word, 16'h1000);
    end
    @(negedge clk);
    if (bit_first) fail_clr = 1'b1; else bit_rd = 1'b1;
    @(negedge clk);
    bit_rd = 1'b0; fail_clr = 1'b0;
    chk(hs_fail_n == 1'b1 && bit_word == 16'h0, "R9 R10 both cleared", {hs_fail_n, bit_word}, 17'h10000);
  endtask

  initial begin
    bit wr, bm;
    int lim, dly;
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    chk(rq_n && ack_n && cs_n && hs_fail_n, "R1 pins idle in reset", {rq_n, ack_n, cs_n, hs_fail_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rq_n && ack_n && cs_n && hs_fail_n && bit_word == 0 && req_ready && !rsp_valid,
        "R1 reset state", {rq_n, ack_n, cs_n, hs_fail_n, req_ready, rsp_valid}, 6'b111110);

    // directed corners
    run_xfer(1'b0, 1'b0, 0, 0, 13'h0155, 16'h0, 0);       // zero deadline, immediate grant
    run_xfer(1'b0, 1'b0, 4, 4, 13'h1ABC, 16'h0, 2);       // grant exactly at deadline
    run_xfer(1'b1, 1'b1, 4, 4, 13'h0F0F, 16'hBEEF, 0);
    run_xfer(1'b0, 1'b1, 4, 5, 13'h0777, 16'h0, 3);       // one cycle late: read aborts
    clear_flags(1'b1);
    run_xfer(1'b1, 1'b0, 3, 200, 13'h0042, 16'h1234, 1);  // grant never comes: write continues
    clear_flags(1'b0);

    for (int k = 0; k < 60; k++) begin
      wr  = $urandom_range(1, 0);
      bm  = $urandom_range(1, 0);
      lim = $urandom_range(7, 0);
      dly = $urandom_range(10, 0);
      run_xfer(wr, bm, lim, dly, AW'($urandom), DW'($urandom), $urandom_range(3, 0));
      if (dly > lim) clear_flags($urandom_range(1, 0));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule